// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block sits at the home node of a distributed shared-memory machine. It keeps one directory entry per memory block: a presence vector with one bit for each processor, and a dirty flag. It accepts read and write requests from processors and decides from the entry how to serve each one.

A request finds its block in one of three states: held by nobody, shared by one or more caches, or held dirty by exactly one owner.

- When the dirty flag is clear, a read is answered from memory.
- When the dirty flag is set, the owner is first asked to give back its copy. Memory is refreshed with the returned data, and that data is then passed to the reader.
- Before a write is granted, every other copy is removed by sending each holder an invalidation and counting their acknowledgements. Only then is exclusive ownership granted.

Requests, replies, outbound interventions and inbound acknowledgements each use their own channel. Back-pressure on one channel cannot wedge another. The engine serves one transaction at a time. While it is busy it refuses new requests, so no block ever has two transactions in flight.

Top module: `dirController`

## Requirements
- R1: After reset every entry has all presence bits and the dirty flag clear. The request channel is ready, and neither the reply channel nor the intervention channel is valid.
- R2: A read of a block whose dirty flag is clear is answered with the memory word, with no intervention sent. The reader's presence bit is set.
- R3: A read of a dirty block sends one intervention of kind 1 (recall and keep a shared copy) to the owner. The data returned with the owner's acknowledgement is written to memory and returned to the reader. The dirty flag is then cleared, and both the owner and the reader are recorded as present.
- R4: A write to a clean block sends an intervention of kind 0 (invalidate) to every present processor except the writer, and to no other processor. The writer then gets a reply with the exclusive flag set, carrying the memory word.
- R5: A reply to a request that sent interventions is issued only after one acknowledgement has arrived for each intervention sent. The count of acknowledgements awaited equals the number of present processors other than the requester.
- R6: Interventions for one transaction go out on consecutive handshakes, without waiting for any acknowledgement. They are sent in ascending processor-index order.
- R7: After a write completes, the block is dirty and only the writer is present. The next read by another processor therefore recalls from the writer alone.
- R8: A write to a dirty block sends one intervention of kind 2 (recall and invalidate) to the owner. The owner's returned data goes to the writer as an exclusive reply, and ownership passes to the writer.
- R9: From the handshake that accepts a request until the handshake that delivers its reply, the request channel is not ready.
- R10: A valid intervention or reply that is held back by its ready signal keeps its destination, kind and data unchanged until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write (exclusive) request, 0 = read |
| reqSrc | input | PROC_W | Requesting processor |
| reqAddr | input | ADDR_W | Block index |
| rspValid | output | 1 | Reply present |
| rspReady | input | 1 | Reply taken |
| rspDst | output | PROC_W | Processor receiving the reply |
| rspAddr | output | ADDR_W | Block of the reply |
| rspData | output | DATA_W | Block data |
| rspExcl | output | 1 | Reply grants exclusive ownership |
| fwdValid | output | 1 | Intervention present |
| fwdReady | input | 1 | Intervention taken |
| fwdDst | output | PROC_W | Target cache |
| fwdAddr | output | ADDR_W | Block of the intervention |
| fwdKind | output | 2 | 0 invalidate, 1 recall to shared, 2 recall and invalidate |
| ackValid | input | 1 | Acknowledgement arriving (always accepted) |
| ackSrc | input | PROC_W | Acknowledging cache |
| ackHasData | input | 1 | Acknowledgement carries block data |
| ackData | input | DATA_W | Returned block data |
| memAddr | output | ADDR_W | Memory block address |
| memRdData | input | DATA_W | Memory read data, valid in the same cycle as memAddr |
| memWe | output | 1 | Memory write strobe |
| memWrData | output | DATA_W | Memory write data |

## Verification
Most internal faults reach the ports within one transaction:

- A wrong presence vector shows up the next time the block is written or recalled. Either an intervention reaches the wrong cache, or the number of interventions is wrong.
- A corrupt acknowledgement counter either releases the reply while the intervention channel still owes acknowledgements, or never releases it at all.
- A dirty flag that is wrong either returns stale memory data to a reader or skips the write-back that memory must receive.

The bench therefore checks every intervention handshake and every reply against a directory model that it keeps itself. It also reads memory back after each transaction.

// File: rtl/dirPkg.sv
package dirPkg;
  typedef enum logic [1:0] {
    FWD_INV          = 2'd0,
    FWD_RECALL_SHARE = 2'd1,
    FWD_RECALL_INV   = 2'd2
  } fwdKindE;

  typedef struct packed {
    logic latchReq;
    logic loadEntry;
    logic fwdFire;
    logic commit;
  } dirStrobeS;
endpackage

// File: rtl/dirDatapath.sv
module dirDatapath
  import dirPkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 16,
  localparam int PROC_W = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 1,
  localparam int ADDR_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int CNT_W  = $clog2(NUM_PROCS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dirStrobeS         strobe,
  input  logic              reqWrite,
  input  logic [PROC_W-1:0] reqSrc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              ackValid,
  input  logic              ackHasData,
  input  logic [DATA_W-1:0] ackData,
  output logic              pendingAny,
  output logic              countZero,
  output logic [PROC_W-1:0] fwdDst,
  output logic [1:0]        fwdKind,
  output logic [ADDR_W-1:0] curAddr,
  output logic [PROC_W-1:0] curSrc,
  output logic              curWrite,
  output logic [DATA_W-1:0] replyData,
  output logic              memWe,
  output logic [DATA_W-1:0] memWrData
);
  function automatic logic [CNT_W-1:0] popCnt(input logic [NUM_PROCS-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int k = 0; k < NUM_PROCS; k++) n = n + CNT_W'(v[k]);
    return n;
  endfunction

  function automatic logic [PROC_W-1:0] lowIdx(input logic [NUM_PROCS-1:0] v);
    logic [PROC_W-1:0] idx;
    idx = '0;
    for (int k = NUM_PROCS - 1; k >= 0; k--) if (v[k]) idx = PROC_W'(k);
    return idx;
  endfunction

  logic [NUM_PROCS-1:0] presence [NUM_BLOCKS];
  logic [NUM_BLOCKS-1:0] dirtyBits;
  logic [NUM_PROCS-1:0] pendMask;
  logic [CNT_W-1:0]     ackCount;
  logic [DATA_W-1:0]    dataReg;
  fwdKindE              kindReg;

  logic [NUM_PROCS-1:0] reqBit, entryPres, nextPend;
  logic                 entryDirty;
  logic                 ackTaken;

  assign reqBit     = NUM_PROCS'(1) << curSrc;
  assign entryPres  = presence[curAddr];
  assign entryDirty = dirtyBits[curAddr];
  assign ackTaken   = ackValid && (ackCount != '0);

  always_comb begin
    if (curWrite)        nextPend = entryPres & ~reqBit;
    else if (entryDirty) nextPend = entryPres & ~reqBit;
    else                 nextPend = '0;
  end

  // directory entry per block
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        presence[b]  <= '0;
        dirtyBits[b] <= 1'b0;
      end else if (strobe.commit && curAddr == ADDR_W'(b)) begin
        if (curWrite) begin
          presence[b]  <= reqBit;
          dirtyBits[b] <= 1'b1;
        end else begin
          presence[b]  <= presence[b] | reqBit;
          dirtyBits[b] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      curSrc   <= '0;
      curWrite <= 1'b0;
      pendMask <= '0;
      ackCount <= '0;
      dataReg  <= '0;
      kindReg  <= FWD_INV;
    end else begin
      if (strobe.latchReq) begin
        curAddr  <= reqAddr;
        curSrc   <= reqSrc;
        curWrite <= reqWrite;
      end
      if (strobe.loadEntry) begin
        pendMask <= nextPend;
        ackCount <= popCnt(nextPend);
        dataReg  <= memRdData;
        if (!curWrite)       kindReg <= FWD_RECALL_SHARE;
        else if (entryDirty) kindReg <= FWD_RECALL_INV;
        else                 kindReg <= FWD_INV;
      end else begin
        if (strobe.fwdFire) pendMask <= pendMask & (pendMask - NUM_PROCS'(1));
        if (ackTaken) begin
          ackCount <= ackCount - CNT_W'(1);
          if (ackHasData) dataReg <= ackData;
        end
      end
    end
  end

  assign pendingAny = |pendMask;
  assign countZero  = (ackCount == '0);
  assign fwdDst     = lowIdx(pendMask);
  assign fwdKind    = kindReg;
  assign replyData  = dataReg;
  assign memWe      = ackTaken && ackHasData;
  assign memWrData  = ackData;
endmodule

// File: rtl/dirControl.sv
module dirControl
  import dirPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      rspReady,
  input  logic      fwdReady,
  input  logic      pendingAny,
  input  logic      countZero,
  output logic      reqReady,
  output logic      rspValid,
  output logic      fwdValid,
  output dirStrobeS strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_DECIDE, ST_COLLECT, ST_REPLY} stateE;
  stateE state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    reqReady  = 1'b0;
    rspValid  = 1'b0;
    fwdValid  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          stateNext = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        strobe.loadEntry = 1'b1;
        stateNext = ST_COLLECT;
      end
      ST_COLLECT: begin
        fwdValid       = pendingAny;
        strobe.fwdFire = pendingAny && fwdReady;
        if (!pendingAny && countZero) stateNext = ST_REPLY;
      end
      ST_REPLY: begin
        rspValid = 1'b1;
        if (rspReady) begin
          strobe.commit = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/dirController.sv
module dirController
  import dirPkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 16,
  localparam int PROC_W = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 1,
  localparam int ADDR_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [PROC_W-1:0] reqSrc,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [PROC_W-1:0] rspDst,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [DATA_W-1:0] rspData,
  output logic              rspExcl,
  output logic              fwdValid,
  input  logic              fwdReady,
  output logic [PROC_W-1:0] fwdDst,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [1:0]        fwdKind,
  input  logic              ackValid,
  input  logic [PROC_W-1:0] ackSrc,
  input  logic              ackHasData,
  input  logic [DATA_W-1:0] ackData,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWe,
  output logic [DATA_W-1:0] memWrData
);
  dirStrobeS            strobe;
  logic                 pendingAny, countZero, curWrite;
  logic [ADDR_W-1:0]    curAddr;
  logic [PROC_W-1:0]    curSrc;
  logic [DATA_W-1:0]    replyData;
  logic [PROC_W-1:0]    ackSrcUnused;

  assign ackSrcUnused = ackSrc;

  dirControl u_ctrl (
    .clk, .rstN, .reqValid, .rspReady, .fwdReady,
    .pendingAny, .countZero, .reqReady, .rspValid, .fwdValid, .strobe
  );

  dirDatapath #(
    .NUM_PROCS(NUM_PROCS), .NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W)
  ) u_dp (
    .clk, .rstN, .strobe, .reqWrite, .reqSrc, .reqAddr, .memRdData,
    .ackValid, .ackHasData, .ackData, .pendingAny, .countZero,
    .fwdDst, .fwdKind, .curAddr, .curSrc, .curWrite, .replyData,
    .memWe, .memWrData
  );

  assign memAddr = curAddr;
  assign fwdAddr = curAddr;
  assign rspAddr = curAddr;
  assign rspDst  = curSrc;
  assign rspExcl = curWrite;
  assign rspData = replyData;
endmodule

// File: rtl/dirControllerChecker.sv
module dirControllerChecker #(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 16,
  localparam int PROC_W = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 1,
  localparam int CNT_W  = $clog2(NUM_PROCS + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspReady,
  input logic [PROC_W-1:0] rspDst,
  input logic [DATA_W-1:0] rspData,
  input logic              fwdValid,
  input logic              fwdReady,
  input logic [PROC_W-1:0] fwdDst,
  input logic [1:0]        fwdKind,
  input logic              ackValid,
  input logic              memWe
);
  logic [CNT_W-1:0] outstanding;
  logic             fwdFire, ackSeen;

  assign fwdFire = fwdValid && fwdReady;
  assign ackSeen = ackValid && (outstanding != '0);

  always_ff @(posedge clk) begin
    if (!rstN) outstanding <= '0;
    else outstanding <= outstanding + CNT_W'(fwdFire) - CNT_W'(ackSeen);
  end

  a_r9_busy_no_accept: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid || fwdValid) |-> !reqReady);

  a_r5_reply_after_acks: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (outstanding == '0));

  a_r4_no_self_inval: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> (fwdDst != rspDst));

  a_r3_writeback_in_recall: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (outstanding != '0));

  a_r10_fwd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && !fwdReady) |=> (fwdValid && $stable(fwdDst) && $stable(fwdKind)));

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspData) && $stable(rspDst)));
endmodule

bind dirController dirControllerChecker #(
  .NUM_PROCS(NUM_PROCS), .NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W)
) u_checker (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .rspReady(rspReady), .rspDst(rspDst), .rspData(rspData),
  .fwdValid(fwdValid), .fwdReady(fwdReady), .fwdDst(fwdDst),
  .fwdKind(fwdKind), .ackValid(ackValid), .memWe(memWe)
);

// File: tb/test_dirController.sv
`timescale 1ns/1ps
module test_dirController;
  localparam int NP = 4;
  localparam int NB = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic          reqValid = 0, reqWrite = 0, rspReady = 0, fwdReady = 0;
  logic          ackValid = 0, ackHasData = 0;
  logic [1:0]    reqSrc = 0, ackSrc = 0;
  logic [2:0]    reqAddr = 0;
  logic [DW-1:0] ackData = 0;
  logic          reqReady, rspValid, rspExcl, fwdValid, memWe;
  logic [1:0]    rspDst, fwdDst, fwdKind;
  logic [2:0]    rspAddr, fwdAddr, memAddr;
  logic [DW-1:0] rspData, memRdData, memWrData;

  logic [DW-1:0] memArr [NB];
  assign memRdData = memArr[memAddr];
  always_ff @(posedge clk) if (memWe) memArr[memAddr] <= memWrData;

  dirController #(.NUM_PROCS(NP), .NUM_BLOCKS(NB), .DATA_W(DW)) i_dirController (.*);

  int vectors = 0, miscompares = 0;
  logic [NP-1:0] refPres  [NB];
  logic          refDirty [NB];
  logic [DW-1:0] refMem   [NB];
  logic [DW-1:0] ownerVal [NB];

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    miscompares++;
    $display("FAIL watchdog actual=0 expected=1");
    finishRun();
  end

  task automatic doTxn(input logic w, input int src, input int addr,
                       input logic stallFwd, input logic stallRsp, input logic [DW-1:0] newVal);
    logic [NP-1:0] expPend, issued;
    int            expKind, nExp, idx, guard, order[NP];
    logic [DW-1:0] expData;
    logic          stalled, lastFired;
    int            stallDst;
    expPend = refPres[addr] & ~(NP'(1) << src);
    if (!w && !refDirty[addr]) expPend = '0;
    expKind = !w ? 1 : (refDirty[addr] ? 2 : 0);
    expData = refDirty[addr] ? ownerVal[addr] : refMem[addr];
    nExp = $countones(expPend);

    @(negedge clk);
    reqValid = 1; reqWrite = w; reqSrc = 2'(src); reqAddr = 3'(addr);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0;

    idx = 0; guard = 0; stalled = 0; lastFired = 0; issued = '0; stallDst = 0;
    while (idx < nExp && guard < 50) begin
      guard++;
      chk(!rspValid, "R5 no reply before interventions done", rspValid, 0);
      chk(!reqReady, "R9 busy stalls requests", reqReady, 0);
      if (fwdValid) begin
        if (stallFwd && !stalled) begin
          fwdReady = 0; stalled = 1; stallDst = fwdDst;
        end else begin
          int want;
          logic [NP-1:0] rem;
          rem = expPend & ~issued;
          want = 0;
          for (int k = NP - 1; k >= 0; k--) if (rem[k]) want = k;
          if (stalled && idx == 0) chk(fwdDst == 2'(stallDst), "R10 stalled intervention held", fwdDst, stallDst);
          chk(fwdDst == 2'(want), w ? "R4 invalidate target order R6" : "R3 recall target", fwdDst, want);
          chk(fwdKind == 2'(expKind), expKind == 2 ? "R8 intervention kind" : "R4 R3 intervention kind", fwdKind, expKind);
          fwdReady = 1;
          order[idx] = want; issued[want] = 1'b1; idx++;
        end
        lastFired = fwdReady;
      end else begin
        if (lastFired && idx > 0) chk(0, "R6 interventions back to back", 0, 1);
        fwdReady = 0; lastFired = 0;
      end
      @(negedge clk);
    end
    fwdReady = 0;
    chk(idx == nExp, "R5 intervention count", idx, nExp);
    chk(!fwdValid, "R4 no extra intervention", fwdValid, 0);

    for (int a = idx - 1; a >= 0; a--) begin
      chk(!rspValid, "R5 reply waits for acknowledgements", rspValid, 0);
      ackValid = 1; ackSrc = 2'(order[a]);
      ackHasData = (expKind != 0); ackData = ownerVal[addr];
      @(negedge clk);
      ackValid = 0; ackHasData = 0;
      @(negedge clk);
    end

    guard = 0;
    while (!rspValid && guard < 20) begin guard++; @(negedge clk); end
    chk(rspValid, "R5 reply issued", rspValid, 1);
    if (stallRsp) begin
      @(negedge clk);
      chk(rspValid && rspData == expData, "R10 reply held under back-pressure", rspData, expData);
    end
    chk(rspDst == 2'(src), "R2 reply destination", rspDst, src);
    chk(rspAddr == 3'(addr), "R2 reply address", rspAddr, addr);
    chk(rspExcl == w, "R4 exclusive flag", rspExcl, w);
    chk(rspData == expData,
        refDirty[addr] ? (w ? "R8 owner data to writer" : "R3 recalled data") : "R2 R4 memory data",
        rspData, expData);
    rspReady = 1;
    @(negedge clk);
    rspReady = 0;
    chk(reqReady && !rspValid, "R9 ready again after reply", reqReady, 1);

    if (refDirty[addr]) refMem[addr] = ownerVal[addr];
    chk(memArr[addr] == refMem[addr], "R3 memory refreshed by recall", memArr[addr], refMem[addr]);
    if (w) begin
      refPres[addr] = NP'(1) << src; refDirty[addr] = 1; ownerVal[addr] = newVal;
    end else begin
      refPres[addr] = refPres[addr] | (NP'(1) << src); refDirty[addr] = 0;
    end
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin
      memArr[b] = DW'(b * 16'h111 + 5);
      refMem[b] = DW'(b * 16'h111 + 5);
      refPres[b] = '0; refDirty[b] = 0; ownerVal[b] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(reqReady, "R1 reset request ready", reqReady, 1);
    chk(!rspValid, "R1 reset no reply", rspValid, 0);
    chk(!fwdValid, "R1 reset no intervention", fwdValid, 0);

    // R1: first write to an untouched block sends nothing
    doTxn(1, 2, 7, 0, 0, 16'hBEEF);
    doTxn(0, 0, 7, 1, 1, 16'h0);

    for (int a = 0; a < 7; a++) begin
      int p;
      p = a % NP;
      for (int q = 0; q < NP; q++) doTxn(0, q, a, 0, 0, 16'h0);           // R2
      doTxn(1, p, a, a[0], a[1], DW'(16'hA000 + a * 16 + p));             // R4 R5 R6
      doTxn(0, (p + 1) % NP, a, a[1], 0, 16'h0);                          // R7 R3
      doTxn(1, (p + 2) % NP, a, 0, a[0], DW'(16'hB000 + a * 16 + p));     // R4
      doTxn(1, (p + 3) % NP, a, a[0], 0, DW'(16'hC000 + a * 16 + p));     // R8
      doTxn(0, p, a, 0, 1, 16'h0);                                        // R3
      doTxn(1, (p + 1) % NP, a, 1, 0, DW'(16'hD000 + a * 16 + p));        // R4 R6
    end
    finishRun();
  end
endmodule